// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies two unsigned operands by adding the multiplicand into an accumulating product once for every unit of the multiplier. A pulse on `start` while the unit is idle captures both operands and clears the product. The captured multiplier then counts down to zero, and the multiplicand is added into the product at each step.

The design has a two-state controller and a separate datapath. The datapath holds the multiplicand register, the count-down multiplier register, the double-width product register, a zero detector on the count, and two adders. One adder is double width and accumulates the product. The other is single width and decrements the count by adding an all-ones word. The zero flag goes back to the controller and decides each step. The controller drives the datapath through a small struct of strobes.

A result takes the multiplier value plus one cycle after the load edge. `ready` is high whenever the unit is idle. The product stays on `product` until the next start.

Top module: `rpt_mult`

## Requirements
- R1: A synchronous active-high reset makes `ready` high and `product` zero at the next clock edge, and it also clears the operand and count registers.
- R2: While idle with `start` low, `ready` stays high and `product` holds its value, whatever the operand inputs do.
- R3: A clock edge with `ready` and `start` both high captures both operands and clears `product`. `ready` is low from that edge on.
- R4: On each busy edge where the remaining count is nonzero, the product grows by exactly the captured multiplicand and the count drops by exactly one. `product` therefore reads multiplicand × k after k steps.
- R5: On a busy edge where the remaining count is zero, the unit returns to idle and `ready` rises. `ready` is low for exactly multiplier + 1 cycles after the load edge.
- R6: When `ready` returns high, `product` equals the unsigned product of the captured operands at full 2·W width (default W = 8; for example, 5 × 4 = 20 and 255 × 255 = 65025).
- R7: A multiplier of zero gives a product of zero after exactly one busy cycle, with no addition.
- R8: While busy, `start` and changes on the operand inputs have no effect. The captured multiplicand and the final product come from the operands loaded at the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | W | Operand added once per step |
| multiplier | input | W | Operand giving the number of additions |
| product | output | 2·W | Accumulated product |
| ready | output | 1 | High while idle; result valid |

## Verification
The bound checker watches every cycle for the reset state, the load, each accumulation step, the count decrement, the exit on zero, the product holding while idle and the captured multiplicand staying fixed while busy. These are the properties of R1 to R5 and R8. The overall numeric result (R6) and the exact busy length in cycles (R5, R7) can only be shown by the bench scenarios. Those scenarios run operand pairs that include zero, one and the largest values, and compare the result against a product computed in the bench. Ignoring a mid-run start and a reset arriving mid-run are also shown only by directed scenarios.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CHECK = 1'b1
  } ctrlState_e;

  typedef struct packed {
    logic loadOps;    // capture operands, clear product
    logic accumStep;  // add multiplicand, decrement count
  } ctrlStrobes_t;

endpackage

// File: rtl/rpt_adder.sv
module rpt_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sum
);
  always_comb sum = opA + opB;
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         countZero,
  output ctrlStrobes_t strobes,
  output logic         ready
);
  ctrlState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.loadOps = 1'b1;
          stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (countZero) begin
          stateD = ST_IDLE;
        end else begin
          strobes.accumStep = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign ready = (stateQ == ST_IDLE);
endmodule

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import rpt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  ctrlStrobes_t   strobes,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic [2*W-1:0] productQ,
  output logic [W-1:0]   mcandQ,
  output logic [W-1:0]   countQ,
  output logic           countZero
);
  localparam int PW = 2 * W;

  logic [W-1:0]  countDec;
  logic [PW-1:0] prodSum;

  // decrement by adding an all-ones word (two's-complement minus one)
  rpt_adder #(.W(W)) u_dec (
    .opA (countQ),
    .opB ({W{1'b1}}),
    .sum (countDec)
  );

  rpt_adder #(.W(PW)) u_acc (
    .opA (productQ),
    .opB ({{(PW-W){1'b0}}, mcandQ}),
    .sum (prodSum)
  );

  assign countZero = (countQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandQ   <= '0;
      countQ   <= '0;
      productQ <= '0;
    end else if (strobes.loadOps) begin
      mcandQ   <= multiplicand;
      countQ   <= multiplier;
      productQ <= '0;
    end else if (strobes.accumStep) begin
      countQ   <= countDec;
      productQ <= prodSum;
    end
  end
endmodule

// File: rtl/rpt_mult.sv
module rpt_mult
  import rpt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic [2*W-1:0] product,
  output logic           ready
);
  ctrlStrobes_t strobes;
  logic         countZero;
  logic [W-1:0] mcandQ;
  logic [W-1:0] countQ;

  rpt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .countZero (countZero),
    .strobes   (strobes),
    .ready     (ready)
  );

  rpt_datapath #(.W(W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .productQ     (product),
    .mcandQ       (mcandQ),
    .countQ       (countQ),
    .countZero    (countZero)
  );
endmodule

// File: rtl/rpt_mult_chk.sv
module rpt_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [2*W-1:0] product,
  input logic           ready,
  input logic [W-1:0]   mcandQ,
  input logic [W-1:0]   countQ
);
  localparam int PW = 2 * W;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ready && product == '0 && countQ == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> (ready && $stable(product)));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (!ready && product == '0));

  p_accum_r4: assert property (@(posedge clk) disable iff (rst)
    (!ready && countQ != '0) |=>
      (product == $past(product) + PW'($past(mcandQ))));

  p_countdown_r4: assert property (@(posedge clk) disable iff (rst)
    (!ready && countQ != '0) |=> (countQ == $past(countQ) - W'(1)));

  p_finish_r5: assert property (@(posedge clk) disable iff (rst)
    (!ready && countQ == '0) |=> (ready && $stable(product)));

  p_busy_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(mcandQ));
endmodule

bind rpt_mult rpt_mult_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .product (product),
  .ready   (ready),
  .mcandQ  (mcandQ),
  .countQ  (countQ)
);

// File: tb/sim_rpt_mult.sv
module sim_rpt_mult;
  localparam int W  = 8;
  localparam int PW = 2 * W;
  localparam int NV = 10;
  localparam logic [W-1:0] VEC_A [NV] = '{8'd5, 8'd0, 8'd7, 8'd1, 8'd255, 8'd13, 8'd200, 8'd3, 8'd1, 8'd0};
  localparam logic [W-1:0] VEC_B [NV] = '{8'd4, 8'd7, 8'd0, 8'd1, 8'd255, 8'd11, 8'd3, 8'd200, 8'd0, 8'd0};

  logic clk = 1'b0;
  logic rst, start;
  logic [W-1:0] multiplicand, multiplier;
  logic [PW-1:0] product;
  logic ready;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rpt_mult #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .ready(ready)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // starts a run and follows it; checks R3, R4, R5/R7, R6
  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b, input bit midStart);
    int busy = 0;
    bit stepOk = 1'b1;
    longint badVal = 0;
    longint badExp = 0;
    multiplicand = a;
    multiplier = b;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(!ready && product == 0, "R3 load", {ready, product}, 0);
    while (!ready && busy < 1000) begin
      if (busy <= int'(b) && product != PW'(a) * PW'(busy)) begin
        stepOk = 1'b0;
        badVal = product;
        badExp = longint'(a) * busy;
      end
      if (midStart && busy == 2) begin
        start = 1'b1;
        multiplicand = ~a;
        multiplier = b ^ 8'h5a;
      end
      tick();
      start = 1'b0;
      busy++;
    end
    chk(stepOk, "R4 step", badVal, badExp);
    chk(busy == int'(b) + 1, (b == 0) ? "R7 zero latency" : "R5 latency", busy, int'(b) + 1);
    chk(product == PW'(a) * PW'(b), (b == 0) ? "R7 zero product" : "R6 result", product, longint'(a) * b);
  endtask

  initial begin
    rst = 1'b1;
    start = 1'b0;
    multiplicand = '0;
    multiplier = '0;
    tick();
    tick();
    chk(ready && product == 0, "R1 reset state", product, 0);
    rst = 1'b0;
    tick();

    for (int i = 0; i < NV; i++) begin
      runMul(VEC_A[i], VEC_B[i], 1'b0);
    end

    // R2: idle hold with operand inputs changing
    runMul(8'd9, 8'd6, 1'b0);
    for (int k = 0; k < 5; k++) begin
      multiplicand = 8'(k * 37 + 1);
      multiplier = 8'(k * 11 + 3);
      tick();
    end
    chk(ready && product == 54, "R2 idle hold", product, 54);

    // R8: start and operand changes during a run are ignored
    runMul(8'd12, 8'd10, 1'b1);
    chk(ready, "R8 back to idle", ready, 1);

    // R1: reset in the middle of a run
    multiplicand = 8'd50;
    multiplier = 8'd40;
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(ready && product == 0, "R1 mid-run reset", product, 0);
    tick();
    chk(ready && product == 0, "R1 stays idle after reset", product, 0);

    // unit works again after reset
    runMul(8'd17, 8'd3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule